// File: doc/BRIEF.md
# Multi-Cycle Eight-Bit Register Processor Core

This block is a small processor core with separate program and data memories. Each 16-bit instruction word carries four fields. The top four bits are the operation code and the next four bits name the destination register Rn. The low byte is either an immediate value, a data address or a branch offset, and its top nibble also names a source register Rm. Sixteen 8-bit general registers feed an adder/subtractor. The core can load from data memory, store to it directly or through a register, load an immediate, add, subtract, and branch relative to the current instruction when a register is zero.

Every instruction takes exactly five clock cycles, one for each step: instruction fetch, decode, operand read from data memory, execute, and result write. A step with no work still takes its cycle. The instruction memory is read asynchronously at the program counter. The data memory is synchronous: read data is expected one cycle after a registered read strobe, and a write is taken on the clock edge that ends a cycle with the write strobe high. An operation code from 7 to 15 stops the core. `halted` then stays high and the program counter holds the address of the offending instruction until reset.

Top module: `tiny8_core`

## Requirements
- R1: A synchronous active-high reset sets the program counter (`imem_addr`) to 0, clears `halted`, `dmem_rd` and `dmem_wr`, and clears all sixteen registers to 0.
- R2: Each instruction occupies five cycles. After a non-branching instruction, `imem_addr` increases by one, exactly five clock edges after the fetch of that instruction began.
- R3: Opcode 0 (word bits 15:12 = 0000) loads Rn (bits 11:8) from data address bits 7:0. `dmem_rd` is high only during the third step, with `dmem_addr` equal to that address.
- R4: Opcode 1 writes Rn to data address bits 7:0. `dmem_wr` is high only during the fifth step.
- R5: Opcode 2 writes Rm (bits 7:4) to the data address held in Rn. The data address in bits 7:0 of the word is not used.
- R6: Opcode 3 loads bits 7:0 of the word into Rn.
- R7: Opcode 4 sets Rn = Rn + Rm modulo 256, with no carry kept.
- R8: Opcode 5 sets Rn = Rn - Rm modulo 256. The operand order matters.
- R9: Opcode 6 with Rn equal to 0 sets the program counter to the address of that instruction plus bits 7:0 read as a signed 8-bit offset. Both forward and backward branches are supported.
- R10: Opcode 6 with Rn not equal to 0 continues at the next instruction.
- R11: Opcodes 7 to 15 raise `halted` two clock edges after their fetch begins. `halted` then stays high, `imem_addr` stays frozen on that instruction, and no further data write occurs until reset.
- R12: `dmem_rd` and `dmem_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 10 | Program counter, address of the instruction word being fetched |
| imem_data | input | 16 | Instruction word at `imem_addr`, read asynchronously |
| dmem_addr | output | 8 | Data memory address for a read or write |
| dmem_rd | output | 1 | Data read strobe; data is expected on `dmem_rdata` one cycle later |
| dmem_wr | output | 1 | Data write strobe |
| dmem_wdata | output | 8 | Data to be written |
| dmem_rdata | input | 8 | Data memory read data |
| halted | output | 1 | High and held once an undefined opcode has been decoded |

## Verification
Directed programs exercise each opcode. The operand values are chosen so that a wrong field or a wrong order gives a different byte. The arithmetic cases:
- An addition that overflows and one that does not, which separates correct modulo arithmetic from a stuck or saturating result.
- Two subtractions with swapped operands, which catch a reversed Rn/Rm order.
- An indirect store whose register address differs from its low byte, which shows which address is used.

A countdown loop uses a backward taken branch, forward not-taken branches and a final forward taken exit, and the sum it stores exposes any wrong target or condition. A separate forward skip over a register load shows that a taken branch discards the skipped instruction. Cycle-exact probes of the strobes and the program counter pin down the five-step timing. Runs with two different undefined opcodes show the stop, the frozen program counter and the suppressed store that follows.

// File: rtl/tiny8_pkg.sv
package tiny8_pkg;

  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_LDD = 4'd0;  // Rn <- mem[imm]
  localparam logic [OPC_W-1:0] OPC_STD = 4'd1;  // mem[imm] <- Rn
  localparam logic [OPC_W-1:0] OPC_STI = 4'd2;  // mem[Rn] <- Rm
  localparam logic [OPC_W-1:0] OPC_LDI = 4'd3;  // Rn <- imm
  localparam logic [OPC_W-1:0] OPC_ADD = 4'd4;  // Rn <- Rn + Rm
  localparam logic [OPC_W-1:0] OPC_SUB = 4'd5;  // Rn <- Rn - Rm
  localparam logic [OPC_W-1:0] OPC_JZ  = 4'd6;  // branch if Rn == 0
  localparam logic [OPC_W-1:0] OPC_LAST = OPC_JZ;

  typedef enum logic [2:0] {
    ST_FETCH  = 3'd0,
    ST_DECODE = 3'd1,
    ST_OPND   = 3'd2,
    ST_EXEC   = 3'd3,
    ST_STORE  = 3'd4,
    ST_HALT   = 3'd5
  } step_t;

endpackage

// File: rtl/tiny8_ctrl.sv
module tiny8_ctrl
  import tiny8_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  illegal,
  output step_t step
);

  always_ff @(posedge clk) begin
    if (rst) begin
      step <= ST_FETCH;
    end else begin
      case (step)
        ST_FETCH:  step <= ST_DECODE;
        ST_DECODE: step <= illegal ? ST_HALT : ST_OPND;
        ST_OPND:   step <= ST_EXEC;
        ST_EXEC:   step <= ST_STORE;
        ST_STORE:  step <= ST_FETCH;
        ST_HALT:   step <= ST_HALT;
        default:   step <= ST_FETCH;
      endcase
    end
  end

endmodule

// File: rtl/tiny8_regfile.sv
module tiny8_regfile #(
  parameter  int W  = 8,
  parameter  int N  = 16,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [W-1:0]  rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_b
);

  logic [W-1:0] regs [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];

endmodule

// File: rtl/tiny8_alu.sv
module tiny8_alu #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] y
);

  // result wraps at W bits, no carry kept
  always_comb begin
    if (sub) y = a - b;
    else     y = a + b;
  end

endmodule

// File: rtl/tiny8_core.sv
module tiny8_core
  import tiny8_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int REG_CNT = 16,
  parameter int IMEM_AW = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  output logic [IMEM_AW-1:0]    imem_addr,
  input  logic [2*DATA_W-1:0]   imem_data,
  output logic [DATA_W-1:0]     dmem_addr,
  output logic                  dmem_rd,
  output logic                  dmem_wr,
  output logic [DATA_W-1:0]     dmem_wdata,
  input  logic [DATA_W-1:0]     dmem_rdata,
  output logic                  halted
);

  localparam int IW     = 2 * DATA_W;
  localparam int RIDX_W = $clog2(REG_CNT);
  localparam int EXT_W  = IMEM_AW - DATA_W;

  step_t               step;
  logic [IW-1:0]       ir_q;
  logic [IMEM_AW-1:0]  pc_q;
  logic [DATA_W-1:0]   opa_q, opb_q, res_q;
  logic [DATA_W-1:0]   rf_a, rf_b, alu_y;
  logic [OPC_W-1:0]    opc;
  logic [RIDX_W-1:0]   rn, rm;
  logic [DATA_W-1:0]   imm;
  logic                illegal, rf_we, take_br;
  logic [IMEM_AW-1:0]  br_off;

  assign opc     = ir_q[IW-1 -: OPC_W];
  assign rn      = ir_q[IW-OPC_W-1 -: RIDX_W];
  assign rm      = ir_q[DATA_W-1 -: RIDX_W];
  assign imm     = ir_q[DATA_W-1:0];
  assign illegal = (opc > OPC_LAST);
  assign br_off  = {{EXT_W{imm[DATA_W-1]}}, imm};
  assign take_br = (opc == OPC_JZ) && (opa_q == '0);

  tiny8_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .illegal (illegal),
    .step    (step)
  );

  assign rf_we = (step == ST_STORE) &&
                 (opc == OPC_LDD || opc == OPC_LDI ||
                  opc == OPC_ADD || opc == OPC_SUB);

  tiny8_regfile #(.W(DATA_W), .N(REG_CNT)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .we      (rf_we),
    .waddr   (rn),
    .wdata   (res_q),
    .raddr_a (rn),
    .rdata_a (rf_a),
    .raddr_b (rm),
    .rdata_b (rf_b)
  );

  tiny8_alu #(.W(DATA_W)) u_alu (
    .a   (opa_q),
    .b   (opb_q),
    .sub (opc == OPC_SUB),
    .y   (alu_y)
  );

  // fetch, operand capture and result staging
  always_ff @(posedge clk) begin
    if (rst) begin
      ir_q  <= '0;
      opa_q <= '0;
      opb_q <= '0;
      res_q <= '0;
    end else begin
      if (step == ST_FETCH) ir_q <= imem_data;
      if (step == ST_DECODE) begin
        opa_q <= rf_a;
        opb_q <= rf_b;
      end
      if (step == ST_EXEC) begin
        case (opc)
          OPC_LDD: res_q <= dmem_rdata;
          OPC_LDI: res_q <= imm;
          default: res_q <= alu_y;
        endcase
      end
    end
  end

  // registered data memory strobes
  always_ff @(posedge clk) begin
    if (rst) begin
      dmem_rd    <= 1'b0;
      dmem_wr    <= 1'b0;
      dmem_addr  <= '0;
      dmem_wdata <= '0;
    end else begin
      dmem_rd <= 1'b0;
      dmem_wr <= 1'b0;
      if (step == ST_DECODE && opc == OPC_LDD) begin
        dmem_rd   <= 1'b1;
        dmem_addr <= imm;
      end
      if (step == ST_EXEC && opc == OPC_STD) begin
        dmem_wr    <= 1'b1;
        dmem_addr  <= imm;
        dmem_wdata <= opa_q;
      end
      if (step == ST_EXEC && opc == OPC_STI) begin
        dmem_wr    <= 1'b1;
        dmem_addr  <= opa_q;
        dmem_wdata <= opb_q;
      end
    end
  end

  // program counter and stop flag
  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= '0;
      halted <= 1'b0;
    end else begin
      if (step == ST_STORE) begin
        if (take_br) pc_q <= pc_q + br_off;
        else         pc_q <= pc_q + IMEM_AW'(1);
      end
      if (step == ST_DECODE && illegal) halted <= 1'b1;
    end
  end

  assign imem_addr = pc_q;

endmodule

// File: rtl/tiny8_core_chk.sv
module tiny8_core_chk #(
  parameter int IAW = 10
) (
  input logic           clk,
  input logic           rst,
  input logic [IAW-1:0] imem_addr,
  input logic           dmem_rd,
  input logic           dmem_wr,
  input logic           halted
);

  // independent step counter, frozen once the core has stopped
  logic [2:0] phase;

  always_ff @(posedge clk) begin
    if (rst)          phase <= 3'd0;
    else if (!halted) phase <= (phase == 3'd4) ? 3'd0 : phase + 3'd1;
  end

  p_no_rd_wr_overlap_r12: assert property (@(posedge clk) disable iff (rst)
    !(dmem_rd && dmem_wr));

  p_rd_third_step_r3: assert property (@(posedge clk) disable iff (rst)
    dmem_rd |-> phase == 3'd2);

  p_wr_fifth_step_r4: assert property (@(posedge clk) disable iff (rst)
    dmem_wr |-> phase == 3'd4);

  p_pc_moves_after_five_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(imem_addr) |-> $past(phase) == 3'd4);

  p_halt_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  p_halt_pc_frozen_r11: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(imem_addr));

  p_halt_no_write_r11: assert property (@(posedge clk) disable iff (rst)
    halted |-> !dmem_wr);

endmodule

bind tiny8_core tiny8_core_chk #(.IAW(IMEM_AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .imem_addr (imem_addr),
  .dmem_rd   (dmem_rd),
  .dmem_wr   (dmem_wr),
  .halted    (halted)
);

// File: tb/test_tiny8_core.sv
`timescale 1ns/1ps
module test_tiny8_core;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  imem_addr;
  logic [15:0] imem_data;
  logic [7:0]  dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_rd, dmem_wr, halted;

  logic [15:0] rom [0:1023];
  logic [7:0]  dmem [0:255];
  logic        pre_we = 1'b0;
  logic [7:0]  pre_a = '0, pre_d = '0;
  int          wr_cnt = 0, both_cnt = 0;
  int          n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  tiny8_core i_tiny8_core (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_rd(dmem_rd), .dmem_wr(dmem_wr),
    .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata), .halted(halted)
  );

  assign imem_data = rom[imem_addr];

  always @(posedge clk) begin
    if (dmem_wr) dmem[dmem_addr] <= dmem_wdata;
    else if (pre_we) dmem[pre_a] <= pre_d;
    if (dmem_rd) dmem_rdata <= dmem[dmem_addr];
    if (dmem_wr) wr_cnt <= wr_cnt + 1;
    if (dmem_rd && dmem_wr) both_cnt <= both_cnt + 1;
  end

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_rom();
    for (int i = 0; i < 1024; i++) rom[i] = 16'h7000;
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst = 1'b1;
    tick(2);
  endtask

  task automatic preset(input logic [7:0] a, input logic [7:0] d);
    pre_a = a; pre_d = d; pre_we = 1'b1;
    tick(1);
    pre_we = 1'b0;
  endtask

  task automatic release_reset();
    rst = 1'b0;
  endtask

  task automatic run_to_halt(input string req, input int limit);
    int n = 0;
    while (!halted && n < limit) begin
      tick(1);
      n++;
    end
    chk(req, "program reached halt", {15'd0, halted}, 16'd1);
  endtask

  // R1, R2, R3, R4: reset state and cycle-exact strobes
  task automatic t_steps();
    clear_rom();
    rom[0] = 16'h0120;  // R1 <- mem[20]
    rom[1] = 16'h1131;  // mem[31] <- R1
    hold_reset();
    preset(8'h20, 8'h5A);
    chk("R1", "pc in reset", {6'd0, imem_addr}, 16'd0);
    chk("R1", "halted in reset", {15'd0, halted}, 16'd0);
    chk("R1", "strobes in reset", {14'd0, dmem_rd, dmem_wr}, 16'd0);
    release_reset();
    tick(2);
    chk("R3", "rd in third step", {15'd0, dmem_rd}, 16'd1);
    chk("R3", "rd address", {8'd0, dmem_addr}, 16'h0020);
    tick(1);
    chk("R3", "rd one cycle", {15'd0, dmem_rd}, 16'd0);
    tick(1);
    chk("R2", "pc before fifth edge", {6'd0, imem_addr}, 16'd0);
    tick(1);
    chk("R2", "pc after fifth edge", {6'd0, imem_addr}, 16'd1);
    tick(4);
    chk("R4", "wr in fifth step", {15'd0, dmem_wr}, 16'd1);
    chk("R4", "wr address", {8'd0, dmem_addr}, 16'h0031);
    chk("R4", "wr data", {8'd0, dmem_wdata}, 16'h005A);
    tick(1);
    chk("R4", "wr one cycle", {15'd0, dmem_wr}, 16'd0);
    chk("R2", "pc second step", {6'd0, imem_addr}, 16'd2);
    tick(2);
    chk("R11", "halt two edges after fetch", {15'd0, halted}, 16'd1);
  endtask

  // R3, R6: direct load and immediate load
  task automatic t_load_imm();
    clear_rom();
    rom[0] = 16'h0120;  // R1 <- mem[20]
    rom[1] = 16'h3577;  // R5 <- 77
    rom[2] = 16'h1130;  // mem[30] <- R1
    rom[3] = 16'h1531;  // mem[31] <- R5
    hold_reset();
    preset(8'h20, 8'hC3);
    release_reset();
    run_to_halt("R6", 200);
    chk("R3", "loaded value", {8'd0, dmem[8'h30]}, 16'h00C3);
    chk("R6", "immediate value", {8'd0, dmem[8'h31]}, 16'h0077);
  endtask

  // R1: registers cleared by reset (R5 was 77 before)
  task automatic t_reset_regs();
    clear_rom();
    rom[0] = 16'h150A;  // mem[0A] <- R5
    hold_reset();
    preset(8'h0A, 8'hAA);
    release_reset();
    run_to_halt("R1", 200);
    chk("R1", "register cleared by reset", {8'd0, dmem[8'h0A]}, 16'h0000);
  endtask

  // R5: store through a register address
  task automatic t_store_ind();
    clear_rom();
    rom[0] = 16'h3345;  // R3 <- 45
    rom[1] = 16'h3499;  // R4 <- 99
    rom[2] = 16'h2340;  // mem[R3] <- R4, low byte 40 unused
    hold_reset();
    preset(8'h40, 8'h11);
    preset(8'h45, 8'h00);
    release_reset();
    run_to_halt("R5", 200);
    chk("R5", "indirect target", {8'd0, dmem[8'h45]}, 16'h0099);
    chk("R5", "low byte not used", {8'd0, dmem[8'h40]}, 16'h0011);
  endtask

  // R7: addition with and without overflow
  task automatic t_add();
    clear_rom();
    rom[0] = 16'h3AF0; rom[1] = 16'h3B25;
    rom[2] = 16'h4AB0;  // RA <- RA + RB
    rom[3] = 16'h1A50;
    rom[4] = 16'h3C03; rom[5] = 16'h3D04;
    rom[6] = 16'h4CD0;
    rom[7] = 16'h1C51;
    hold_reset();
    release_reset();
    run_to_halt("R7", 300);
    chk("R7", "add wraps", {8'd0, dmem[8'h50]}, 16'h0015);
    chk("R7", "add plain", {8'd0, dmem[8'h51]}, 16'h0007);
  endtask

  // R8: subtraction in both operand orders
  task automatic t_sub();
    clear_rom();
    rom[0] = 16'h3110; rom[1] = 16'h3230;
    rom[2] = 16'h5120;  // R1 <- 10 - 30
    rom[3] = 16'h1152;
    rom[4] = 16'h3330; rom[5] = 16'h3410;
    rom[6] = 16'h5340;  // R3 <- 30 - 10
    rom[7] = 16'h1353;
    hold_reset();
    release_reset();
    run_to_halt("R8", 300);
    chk("R8", "sub wraps", {8'd0, dmem[8'h52]}, 16'h00E0);
    chk("R8", "sub order", {8'd0, dmem[8'h53]}, 16'h0020);
  endtask

  // R9, R10: countdown loop and forward skip
  task automatic t_branch();
    clear_rom();
    rom[0]  = 16'h3000;  // R0 <- 0
    rom[1]  = 16'h3105;  // R1 <- 5
    rom[2]  = 16'h3201;  // R2 <- 1
    rom[3]  = 16'h3300;  // R3 <- 0
    rom[4]  = 16'h6104;  // if R1==0 goto 8
    rom[5]  = 16'h4010;  // R0 += R1
    rom[6]  = 16'h5120;  // R1 -= R2
    rom[7]  = 16'h63FD;  // goto 4 (offset -3)
    rom[8]  = 16'h1060;  // mem[60] <- R0
    rom[9]  = 16'h3500;  // R5 <- 0
    rom[10] = 16'h6502;  // goto 12
    rom[11] = 16'h3A11;  // skipped
    rom[12] = 16'h1A61;  // mem[61] <- RA
    hold_reset();
    preset(8'h60, 8'hFF);
    preset(8'h61, 8'hCC);
    release_reset();
    run_to_halt("R9", 2000);
    chk("R9", "loop sum (backward taken, R10 not taken)", {8'd0, dmem[8'h60]}, 16'h000F);
    chk("R9", "forward skip", {8'd0, dmem[8'h61]}, 16'h0000);
    chk("R10", "stop address after loop", {6'd0, imem_addr}, 16'd13);
  endtask

  // R11: undefined opcodes stop the core
  task automatic t_halt();
    int w0;
    clear_rom();
    rom[0] = 16'h3155;
    rom[1] = 16'h8000;  // undefined
    rom[2] = 16'h1170;  // must not run
    hold_reset();
    preset(8'h70, 8'hEE);
    release_reset();
    run_to_halt("R11", 200);
    w0 = wr_cnt;
    chk("R11", "pc on stop", {6'd0, imem_addr}, 16'd1);
    tick(40);
    chk("R11", "pc frozen", {6'd0, imem_addr}, 16'd1);
    chk("R11", "halted held", {15'd0, halted}, 16'd1);
    chk("R11", "no write after stop", 16'(wr_cnt - w0), 16'd0);
    chk("R11", "memory untouched", {8'd0, dmem[8'h70]}, 16'h00EE);
    clear_rom();
    rom[0] = 16'hF123;
    hold_reset();
    chk("R1", "reset clears halted", {15'd0, halted}, 16'd0);
    release_reset();
    tick(1);
    chk("R11", "not halted after one edge", {15'd0, halted}, 16'd0);
    tick(1);
    chk("R11", "opcode F halts", {15'd0, halted}, 16'd1);
    chk("R11", "opcode F pc", {6'd0, imem_addr}, 16'd0);
  endtask

  initial begin
    #(20000 * 10);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    clear_rom();
    for (int i = 0; i < 256; i++) dmem[i] = 8'h00;
    tick(3);
    t_steps();
    t_load_imm();
    t_reset_regs();
    t_store_ind();
    t_add();
    t_sub();
    t_branch();
    t_halt();
    chk("R12", "read and write never together", 16'(both_cnt), 16'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule